// File: doc/BRIEF.md
# IDE Task-File Port Access Decoder

This block sits between a byte-addressed I/O port bus and the task-file registers of one IDE channel. Two windows lead into the channel. The first is an eight-byte command-block window, which holds the data register and the command registers. The second is a four-byte control-block window. Each access carries an offset and a size code. The decoder checks that pair against the legal combinations. A legal access goes to one task-file register over a simple strobe-and-index interface. An illegal one is refused: a refused read answers with all ones across its width, and a refused write never reaches the channel.

The downstream strobes are driven combinationally in the cycle the request is presented. The register's read data is sampled in that same cycle. The response comes back one clock later with a valid strobe, for reads and writes alike. Every request therefore finishes on a fixed schedule, whether it was accepted or refused.

Top module: `ide_port_decoder`

## Requirements
- R1: A byte access (size code 00) to any offset 0..7 of the command-block window is accepted. It pulses the downstream read or write strobe with register index equal to the offset and width code 00.
- R2: A 16-bit (size 01) or 32-bit (size 10) access to the command-block window is accepted only at offset 0. There it drives index 0 with the same width code. At any other offset it is refused.
- R3: The control-block window accepts only a byte access at offset 2. It maps to index 12: bit 3 set marks the control bank, and the low three bits are offset plus 2. A read there returns alternate status and a write sets device control. Every other offset or size in this window is refused.
- R4: A refused read returns all ones across its width in the low bits, with the upper bits zero: 0x000000FF for size 00, 0x0000FFFF for size 01, 0xFFFFFFFF for size 10 and for size 11.
- R5: A refused write asserts neither downstream strobe.
- R6: Size code 11 is refused in both windows.
- R7: A request with both window selects high is refused.
- R8: Response valid is high in exactly the cycle after each request, whether read or write, and low after a cycle with no select. The response data of a write is zero.
- R9: An accepted read returns the downstream read data masked to the access width and zero-extended.
- R10: An accepted write forwards the write data masked to the access width, with the upper bits zero.
- R11: While reset is low, response valid and response data are zero, even if a request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_blk | input | 1 | Request to the command-block window |
| sel_ctl | input | 1 | Request to the control-block window |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Byte offset within the selected window |
| size | input | 2 | 00 byte, 01 16-bit, 10 32-bit, 11 invalid |
| wdata | input | 32 | Write data, low-aligned |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read response data |
| tf_rd | output | 1 | Downstream register read strobe |
| tf_wr | output | 1 | Downstream register write strobe |
| tf_idx | output | 4 | Downstream register index |
| tf_width | output | 2 | Downstream access width code |
| tf_wdata | output | 32 | Downstream write data, width-masked |
| tf_rdata | input | 32 | Downstream read data for the indexed register |

## Verification
The assertions assume that the selects, offset, size and direction are stable around each rising edge. They also assume that a request lasts exactly one cycle from the decoder's point of view, with each cycle of asserted selects counted as its own request. The checks that look back one cycle are gated on the previous cycle having been out of reset, so a request presented during reset cannot trigger them. The stimulus changes every input only on the falling edge and holds it for a whole cycle. Random stimulus covers all four size codes, both windows and the double-select case, and it is biased towards control offset 2 and byte size so that accepted accesses occur often.

// File: rtl/ide_dec_pkg.sv
// Package: shared size encoding and width mask for the task-file decoder.
// Assumes a 32-bit port data path.
package ide_dec_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } acc_size_e;

    // Mask of the bytes an access of the given size covers; code 11 covers all.
    function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] sz);
        logic [DATA_W-1:0] m;
        case (acc_size_e'(sz))
            SZ_BYTE: m = DATA_W'(32'h0000_00FF);
            SZ_HALF: m = DATA_W'(32'h0000_FFFF);
            default: m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ide_access_check.sv
// ide_access_check: decides whether a port access is legal and which task-file
// register it targets. Command-block bytes map to index = offset; wide accesses
// are legal only at offset 0; the control window takes one byte offset, mapped
// into the upper bank with a fixed bias. Assumes at most one request per cycle.
module ide_access_check
    import ide_dec_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int IDX_W    = 4,
    parameter int CTL_OFF  = 2,
    parameter int CTL_BIAS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_blk,
    input  logic              sel_ctl,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              accept,
    output logic              tf_rd,
    output logic              tf_wr,
    output logic [IDX_W-1:0]  tf_idx
);

    localparam int CTL_AW = ADDR_W - 1;
    localparam int LOW_W  = IDX_W - 1;

    logic blk_only, ctl_only, blk_ok, ctl_ok, wide;

    // Legality of the access for each window.
    always_comb begin
        blk_only = sel_blk & ~sel_ctl;
        ctl_only = sel_ctl & ~sel_blk;
        wide     = (acc_size_e'(size) == SZ_HALF) || (acc_size_e'(size) == SZ_WORD);
        blk_ok   = blk_only && ((acc_size_e'(size) == SZ_BYTE) ||
                                (wide && (addr == '0)));
        ctl_ok   = ctl_only && (acc_size_e'(size) == SZ_BYTE) &&
                   (addr == ADDR_W'(CTL_OFF));
        accept   = blk_ok | ctl_ok;
    end

    // Register index: offset in the lower bank, biased offset in the upper bank.
    always_comb begin
        if (ctl_only)
            tf_idx = {1'b1, LOW_W'(addr[CTL_AW-1:0]) + LOW_W'(CTL_BIAS)};
        else
            tf_idx = IDX_W'(addr);
    end

    // Downstream strobes follow the accepted direction.
    always_comb begin
        tf_rd = accept & ~wr_en;
        tf_wr = accept &  wr_en;
    end

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(tf_rd && tf_wr));

    assert_wide_idx_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((tf_rd || tf_wr) && (size != 2'b00)) |-> (tf_idx == '0 && sel_blk));

    assert_ctl_idx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((tf_rd || tf_wr) && sel_ctl) |-> (tf_idx == IDX_W'(12) && size == 2'b00));

    assert_no_size3_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 2'b11) |-> !(tf_rd || tf_wr));

    assert_dual_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_blk && sel_ctl) |-> !(tf_rd || tf_wr));

endmodule

// File: rtl/ide_read_shaper.sv
// ide_read_shaper: forms the read response word. Accepted reads take the
// register data masked to the access width; refused reads give all ones over
// that width; writes give zero. Purely combinational.
module ide_read_shaper
    import ide_dec_pkg::*;
(
    input  logic              wr_en,
    input  logic              accept,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] tf_rdata,
    output logic [DATA_W-1:0] rdata
);

    // Select masked register data, all-ones filler, or zero.
    always_comb begin
        if (wr_en)
            rdata = '0;
        else if (accept)
            rdata = tf_rdata & width_mask(size);
        else
            rdata = width_mask(size);
    end

endmodule

// File: rtl/ide_rsp_reg.sv
// ide_rsp_reg: registers the response so it appears one cycle after the
// request. Each cycle with a select high counts as one request.
module ide_rsp_reg
    import ide_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] rdata_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    // Capture the response word and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req;
            rsp_rdata <= req ? rdata_in : '0;
        end
    end

    assert_rsp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_valid);

    assert_rsp_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rsp_valid);

    assert_wr_rsp_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req && wr_en)) |-> (rsp_rdata == '0));

endmodule

// File: rtl/ide_port_decoder.sv
// ide_port_decoder: top of the task-file port decoder for one IDE channel.
// Validates each access against window, offset and size; forwards legal ones
// to the channel in the request cycle; returns a response one cycle later.
// Assumes requests are presented for one cycle each, with inputs stable.
module ide_port_decoder
    import ide_dec_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_blk,
    input  logic              sel_ctl,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              tf_rd,
    output logic              tf_wr,
    output logic [IDX_W-1:0]  tf_idx,
    output logic [1:0]        tf_width,
    output logic [DATA_W-1:0] tf_wdata,
    input  logic [DATA_W-1:0] tf_rdata
);

    logic              req;
    logic              accept;
    logic [DATA_W-1:0] shaped;

    // Any select counts as a request, legal or not.
    always_comb req = sel_blk | sel_ctl;

    // Width code and masked write data go straight to the channel.
    always_comb begin
        tf_width = size;
        tf_wdata = wdata & width_mask(size);
    end

    ide_access_check #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_check (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_blk (sel_blk),
        .sel_ctl (sel_ctl),
        .wr_en   (wr_en),
        .addr    (addr),
        .size    (size),
        .accept  (accept),
        .tf_rd   (tf_rd),
        .tf_wr   (tf_wr),
        .tf_idx  (tf_idx)
    );

    ide_read_shaper u_shape (
        .wr_en    (wr_en),
        .accept   (accept),
        .size     (size),
        .tf_rdata (tf_rdata),
        .rdata    (shaped)
    );

    ide_rsp_reg u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .wr_en     (wr_en),
        .rdata_in  (shaped),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assert_reject_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req && !wr_en && !tf_rd && size == 2'b00))
        |-> (rsp_rdata == DATA_W'(32'h0000_00FF)));

    assert_reset_quiet_R11: assert property (@(posedge clk)
        $past(!rst_n) |-> (!rsp_valid && rsp_rdata == '0));

endmodule

// File: tb/ide_port_decoder_test.sv
module ide_port_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_blk = 1'b0, sel_ctl = 1'b0, wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [1:0]  size = '0;
    logic [31:0] wdata = '0;
    logic        rsp_valid, tf_rd, tf_wr;
    logic [31:0] rsp_rdata, tf_wdata, tf_rdata;
    logic [3:0]  tf_idx;
    logic [1:0]  tf_width;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    // Channel model: each register returns a fixed pattern of its index.
    function automatic logic [31:0] reg_val(input logic [3:0] i);
        return 32'hC3A5_1E70 ^ {8{i}};
    endfunction

    assign tf_rdata = reg_val(tf_idx);

    ide_port_decoder uut (
        .clk(clk), .rst_n(rst_n), .sel_blk(sel_blk), .sel_ctl(sel_ctl),
        .wr_en(wr_en), .addr(addr), .size(size), .wdata(wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .tf_rd(tf_rd),
        .tf_wr(tf_wr), .tf_idx(tf_idx), .tf_width(tf_width),
        .tf_wdata(tf_wdata), .tf_rdata(tf_rdata)
    );

    function automatic logic [31:0] mask_of(input logic [1:0] s);
        if (s == 2'b00) return 32'h0000_00FF;
        if (s == 2'b01) return 32'h0000_FFFF;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic bit legal(input logic b, input logic c,
                                 input logic [2:0] a, input logic [1:0] s);
        if (b && c) return 1'b0;
        if (b) return (s == 2'b00) || ((s == 2'b01 || s == 2'b10) && a == 3'd0);
        if (c) return (s == 2'b00) && (a == 3'd2);
        return 1'b0;
    endfunction

    function automatic string tag_of(input logic b, input logic c, input logic w,
                                     input logic [2:0] a, input logic [1:0] s);
        if (legal(b, c, a, s)) return c ? "R3" : (s == 2'b00 ? "R1" : "R2");
        if (s == 2'b11) return "R6";
        if (b && c) return "R7";
        return w ? "R5" : "R4";
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic access(input logic b, input logic c, input logic w,
                          input logic [2:0] a, input logic [1:0] s,
                          input logic [31:0] wd);
        bit          ok;
        string       tg;
        logic [3:0]  ei;
        logic [31:0] er;
        @(negedge clk);
        sel_blk = b; sel_ctl = c; wr_en = w; addr = a; size = s; wdata = wd;
        ok = legal(b, c, a, s);
        tg = tag_of(b, c, w, a, s);
        ei = b ? {1'b0, a} : 4'd12;
        #1;
        if (ok) begin
            chk(tf_rd == !w && tf_wr == w, tg, "strobe", {30'd0, tf_rd, tf_wr}, {30'd0, !w, w});
            chk(tf_idx == ei, tg, "index", {28'd0, tf_idx}, {28'd0, ei});
            chk(tf_width == s, tg, "width", {30'd0, tf_width}, {30'd0, s});
            if (w) chk(tf_wdata == (wd & mask_of(s)), "R10", "wdata", tf_wdata, wd & mask_of(s));
        end else begin
            chk(!tf_rd && !tf_wr, tg, "no strobe", {30'd0, tf_rd, tf_wr}, 32'd0);
        end
        er = w ? 32'd0 : (ok ? (reg_val(ei) & mask_of(s)) : mask_of(s));
        @(posedge clk); #1;
        chk(rsp_valid == 1'b1, "R8", "rsp_valid", {31'd0, rsp_valid}, 32'd1);
        chk(rsp_rdata == er, w ? "R8" : (ok ? "R9" : "R4"), "rsp_rdata", rsp_rdata, er);
    endtask

    task automatic idle();
        @(negedge clk);
        sel_blk = 1'b0; sel_ctl = 1'b0;
        @(posedge clk); #1;
        chk(rsp_valid == 1'b0, "R8", "idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0001_DE5A));
        // R11: request during reset must not produce a response.
        @(negedge clk);
        sel_blk = 1'b1; wr_en = 1'b0; addr = 3'd0; size = 2'b00;
        repeat (3) @(posedge clk);
        #1;
        chk(rsp_valid == 1'b0 && rsp_rdata == 32'd0, "R11", "reset state", rsp_rdata, 32'd0);
        @(negedge clk);
        sel_blk = 1'b0;
        rst_n = 1'b1;
        idle();

        // R1: every command-block byte offset, read and write.
        for (int i = 0; i < 8; i++) access(1'b1, 1'b0, 1'b0, 3'(i), 2'b00, 32'h0);
        for (int i = 0; i < 8; i++) access(1'b1, 1'b0, 1'b1, 3'(i), 2'b00, 32'hDEAD_BE00 + 32'(i));
        // R2: wide accesses at offset 0 and off it.
        access(1'b1, 1'b0, 1'b0, 3'd0, 2'b01, 32'h0);
        access(1'b1, 1'b0, 1'b0, 3'd0, 2'b10, 32'h0);
        access(1'b1, 1'b0, 1'b1, 3'd0, 2'b10, 32'h1234_5678);
        access(1'b1, 1'b0, 1'b1, 3'd0, 2'b01, 32'hABCD_9876);
        access(1'b1, 1'b0, 1'b0, 3'd4, 2'b01, 32'h0);
        access(1'b1, 1'b0, 1'b0, 3'd2, 2'b10, 32'h0);
        access(1'b1, 1'b0, 1'b1, 3'd1, 2'b10, 32'hFFFF_FFFF);
        // R3: control window, every offset, byte and wider.
        for (int i = 0; i < 8; i++) access(1'b0, 1'b1, 1'b0, 3'(i), 2'b00, 32'h0);
        access(1'b0, 1'b1, 1'b1, 3'd2, 2'b00, 32'h0000_0A06);
        access(1'b0, 1'b1, 1'b0, 3'd2, 2'b01, 32'h0);
        access(1'b0, 1'b1, 1'b0, 3'd2, 2'b10, 32'h0);
        access(1'b0, 1'b1, 1'b1, 3'd2, 2'b10, 32'h5555_5555);
        // R6: size 11 in both windows.
        access(1'b1, 1'b0, 1'b0, 3'd0, 2'b11, 32'h0);
        access(1'b0, 1'b1, 1'b0, 3'd2, 2'b11, 32'h0);
        access(1'b1, 1'b0, 1'b1, 3'd0, 2'b11, 32'h7777_7777);
        // R7: both selects.
        access(1'b1, 1'b1, 1'b0, 3'd2, 2'b00, 32'h0);
        access(1'b1, 1'b1, 1'b1, 3'd0, 2'b00, 32'h11);
        idle();

        // Constrained random mix.
        for (int n = 0; n < 400; n++) begin
            int r = $urandom % 8;
            logic b = (r < 4) || (r == 7);
            logic c = (r >= 4);
            logic [2:0] a = (c && !b && ($urandom % 2 == 0)) ? 3'd2 : 3'($urandom % 8);
            logic [1:0] s = ($urandom % 2 == 0) ? 2'b00 : 2'($urandom % 4);
            access(b, c, 1'($urandom % 2), a, s, $urandom);
            if ($urandom % 8 == 0) idle();
        end
        idle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule